// File: doc/BRIEF.md
# Key Ladder Certificate Step Sequencer

This block derives a 256-bit key by driving an external key-derivation step engine through a fixed programme of certificate indices. A one-cycle `start` pulse and an 8-bit firmware major version begin a run. The sequencer first issues seven fixed certificates. It then repeats certificate 25 a number of times that depends on the version, and ends with certificate 26. Each step is a full handshake with the engine. The sequencer clears the step status, presents the index with its enable and the done-indication enable, pulses `eng_go`, waits for `eng_done`, clears the status again and only then looks at `eng_err`.

Any engine error, or a version above 254, ends the run with failure: `done` pulses with `ok` low and the key output is zeroed. When every step succeeds, the engine's result register is captured into `key_out` on the cycle `done` pulses with `ok` high. The key keeps that value until the next run ends. The hash inside the engine, interrupt wiring, arbitration with other hash users and key storage all live outside this block.

Top module: `key_ladder_seq`

## Requirements
- R1: The first seven steps of every accepted run carry certificate indices 0, 3, 4, 5, 7, 15 and 20, in that order.
- R2: After those seven steps, certificate 25 is issued exactly (254 - version) times: zero times for version 254 and 254 times for version 0.
- R3: The last step of a successful run is certificate 26, issued once, so a run has 8 + (254 - version) steps in total.
- R4: A start with version above 254 gives `done` high with `ok` low and `key_out` zero in the cycle after the start edge, and no `eng_go` is ever issued for it.
- R5: Before every `eng_go` the sequencer pulses `eng_clr`. `eng_go` is a one-cycle pulse, and `eng_cert_en` and `eng_done_en` are high while it is asserted.
- R6: After `eng_go`, the sequencer waits for `eng_done`, pulses `eng_clr` and then samples `eng_err`. A set error ends the run at once with `done` high, `ok` low and `key_out` zero, and no further `eng_go` follows.
- R7: On success, `key_out` equals `eng_result` as it stood after the final step, and `ok` is high in the `done` cycle.
- R8: `done` is a one-cycle pulse. `busy` rises in the cycle after an accepted start and falls in the same cycle that `done` pulses.
- R9: A `start` pulse while `busy` is high is ignored: the run in progress keeps its version and its step count.
- R10: After reset `busy`, `done`, `ok`, `eng_go` and `key_out` are all zero. Outside a `done` cycle, `key_out` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin a derivation |
| version | input | 8 | Firmware major version, sampled with `start` |
| busy | output | 1 | A derivation is in progress |
| done | output | 1 | One-cycle pulse when a run ends |
| ok | output | 1 | Outcome of the last run, valid with `done` |
| key_out | output | 256 | Derived key, zero after a failed run |
| eng_clr | output | 1 | Clears the engine step status |
| eng_cert_idx | output | 5 | Certificate index for the current step |
| eng_cert_en | output | 1 | Index-enable for the engine |
| eng_done_en | output | 1 | Enables the engine's done indication |
| eng_go | output | 1 | One-cycle step trigger |
| eng_done | input | 1 | Engine step status: step complete |
| eng_err | input | 1 | Engine error flag for the last step |
| eng_result | input | 256 | Engine result register |

## Verification
For a rejected version, `done` is a single register stage from the start edge. The bench therefore samples `done`, `ok` and `key_out` on the falling edge right after the edge that took `start`. For accepted runs the run length depends on the engine's latency, so the bench polls on falling edges until `done` appears, reads `ok` and `key_out` in that same half-cycle, and checks that `busy` has already dropped. The step log and the handshake-order counter come from the stub engine's view of `eng_go`. They are read 20 cycles after `done`, so any step issued late after an abort would still be counted.

// File: rtl/kl_pkg.sv
// Shared constants, types and the certificate table for the key ladder sequencer.
// Assumes 5-bit certificate indices and a seven-entry fixed prefix.
package kl_pkg;
    localparam int CERT_W   = 5;
    localparam int PRE_LEN  = 7;
    localparam logic [CERT_W-1:0] REP_CERT = CERT_W'(25);
    localparam logic [CERT_W-1:0] SUF_CERT = CERT_W'(26);

    typedef enum logic [1:0] {PH_PRE, PH_REP, PH_SUF} phase_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_CLR, ST_SETUP, ST_GO, ST_WAIT, ST_ACK
    } step_st_e;

    // Index of the prefix certificate at position pos; the order is behaviour.
    function automatic logic [CERT_W-1:0] pre_cert(input int unsigned pos);
        case (pos)
            0:       return CERT_W'(0);
            1:       return CERT_W'(3);
            2:       return CERT_W'(4);
            3:       return CERT_W'(5);
            4:       return CERT_W'(7);
            5:       return CERT_W'(15);
            default: return CERT_W'(20);
        endcase
    endfunction
endpackage

// File: rtl/kl_cert_sel.sv
// Certificate selector: maps the current phase and prefix position to the index
// the next step must carry. Purely combinational; assumes pos < PRE_LEN.
module kl_cert_sel
    import kl_pkg::*;
#(
    parameter int POS_W = 3
) (
    input  phase_e                phase,
    input  logic [POS_W-1:0]      pos,
    output logic [CERT_W-1:0]     cert
);
    // Choose the index for the active phase.
    always_comb begin
        unique case (phase)
            PH_PRE:  cert = pre_cert(int'(pos));
            PH_REP:  cert = REP_CERT;
            default: cert = SUF_CERT;
        endcase
    end
endmodule

// File: rtl/kl_rep_counter.sv
// Down-counter for the remaining repetitions of the repeated certificate.
// Assumes load and dec are never asserted in the same cycle.
module kl_rep_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         is_zero,
    output logic         is_one
);
    logic [W-1:0] cnt;

    // Load at run start, count down once per completed repeated step.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (load)    cnt <= load_val;
        else if (dec && cnt != '0) cnt <= cnt - W'(1);
    end

    assign is_zero = (cnt == '0);
    assign is_one  = (cnt == W'(1));
endmodule

// File: rtl/kl_step_ctrl.sv
// One-step handshake controller. On req in idle it latches the index, clears the
// engine status, presents index plus enables, pulses go, waits for done, clears
// the status again and reports fin with the engine error flag sampled then.
// Assumes the engine holds eng_err valid until its next go.
module kl_step_ctrl
    import kl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [CERT_W-1:0] cert_in,
    input  logic              eng_done,
    input  logic              eng_err,
    output logic              idle,
    output logic              fin,
    output logic              fin_err,
    output logic              eng_clr,
    output logic              eng_go,
    output logic              eng_cert_en,
    output logic              eng_done_en,
    output logic [CERT_W-1:0] eng_cert_idx
);
    step_st_e          st;
    logic [CERT_W-1:0] cert_q;

    // Advance through the handshake phases of one step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            cert_q <= '0;
        end else begin
            unique case (st)
                ST_IDLE:  if (req) begin st <= ST_CLR; cert_q <= cert_in; end
                ST_CLR:   st <= ST_SETUP;
                ST_SETUP: st <= ST_GO;
                ST_GO:    st <= ST_WAIT;
                ST_WAIT:  if (eng_done) st <= ST_ACK;
                default:  st <= ST_IDLE;
            endcase
        end
    end

    // Decode the engine-side strobes and the step result from the phase.
    always_comb begin
        logic present;
        present      = (st == ST_SETUP) || (st == ST_GO) || (st == ST_WAIT);
        idle         = (st == ST_IDLE);
        eng_clr      = (st == ST_CLR) || (st == ST_ACK);
        eng_go       = (st == ST_GO);
        eng_cert_en  = present;
        eng_done_en  = present;
        eng_cert_idx = present ? cert_q : '0;
        fin          = (st == ST_ACK);
        fin_err      = (st == ST_ACK) && eng_err;
    end
endmodule

// File: rtl/key_ladder_seq.sv
// Key ladder sequencer top. Accepts a start with a version, rejects versions
// above MAX_VER, then runs the fixed prefix, MAX_VER - version repeated steps
// and one final step through kl_step_ctrl. Captures the engine result on success,
// zeroes the key on failure. Assumes the engine answers every go with done.
module key_ladder_seq
    import kl_pkg::*;
#(
    parameter int KEY_W   = 256,
    parameter int VER_W   = 8,
    parameter int MAX_VER = 254
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [VER_W-1:0]  version,
    output logic              busy,
    output logic              done,
    output logic              ok,
    output logic [KEY_W-1:0]  key_out,
    output logic              eng_clr,
    output logic [CERT_W-1:0] eng_cert_idx,
    output logic              eng_cert_en,
    output logic              eng_done_en,
    output logic              eng_go,
    input  logic              eng_done,
    input  logic              eng_err,
    input  logic [KEY_W-1:0]  eng_result
);
    localparam int POS_W = $clog2(PRE_LEN);
    localparam logic [VER_W-1:0] VER_LIM = VER_W'(MAX_VER);
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(PRE_LEN - 1);

    phase_e            phase;
    logic [POS_W-1:0]  pos;
    logic [CERT_W-1:0] cert_next;
    logic              ctrl_idle, fin, fin_err;
    logic              rep_zero, rep_one;
    logic              accept, bad_ver;

    assign accept  = start && !busy;
    assign bad_ver = (version > VER_LIM);

    kl_cert_sel #(.POS_W(POS_W)) u_sel (
        .phase (phase),
        .pos   (pos),
        .cert  (cert_next)
    );

    kl_rep_counter #(.W(VER_W)) u_rep (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept && !bad_ver),
        .load_val (VER_LIM - version),
        .dec      (fin && !fin_err && phase == PH_REP),
        .is_zero  (rep_zero),
        .is_one   (rep_one)
    );

    kl_step_ctrl u_step (
        .clk          (clk),
        .rst_n        (rst_n),
        .req          (busy && ctrl_idle),
        .cert_in      (cert_next),
        .eng_done     (eng_done),
        .eng_err      (eng_err),
        .idle         (ctrl_idle),
        .fin          (fin),
        .fin_err      (fin_err),
        .eng_clr      (eng_clr),
        .eng_go       (eng_go),
        .eng_cert_en  (eng_cert_en),
        .eng_done_en  (eng_done_en),
        .eng_cert_idx (eng_cert_idx)
    );

    // Run control: accept or reject a start, advance the phase per finished step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            ok      <= 1'b0;
            key_out <= '0;
            phase   <= PH_PRE;
            pos     <= '0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                if (bad_ver) begin
                    done    <= 1'b1;
                    ok      <= 1'b0;
                    key_out <= '0;
                end else begin
                    busy  <= 1'b1;
                    phase <= PH_PRE;
                    pos   <= '0;
                end
            end else if (busy && fin) begin
                if (fin_err) begin
                    busy    <= 1'b0;
                    done    <= 1'b1;
                    ok      <= 1'b0;
                    key_out <= '0;
                end else begin
                    unique case (phase)
                        PH_PRE: begin
                            if (pos == POS_LAST) phase <= rep_zero ? PH_SUF : PH_REP;
                            else                 pos   <= pos + POS_W'(1);
                        end
                        PH_REP: if (rep_one) phase <= PH_SUF;
                        default: begin
                            busy    <= 1'b0;
                            done    <= 1'b1;
                            ok      <= 1'b1;
                            key_out <= eng_result;
                        end
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/kl_seq_checker.sv
// Protocol checker for key_ladder_seq, attached by bind. Watches ports only.
module kl_seq_checker
    import kl_pkg::*;
#(
    parameter int KEY_W   = 256,
    parameter int VER_W   = 8,
    parameter int MAX_VER = 254
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [VER_W-1:0] version,
    input logic             busy,
    input logic             done,
    input logic             ok,
    input logic [KEY_W-1:0] key_out,
    input logic             eng_go,
    input logic             eng_cert_en,
    input logic             eng_done_en
);
    p_go_enabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
        eng_go |-> (eng_cert_en && eng_done_en));

    p_go_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        eng_go |=> !eng_go);

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_busy_ends_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    p_fail_key_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !ok) |-> (key_out == '0));

    p_bad_version_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && version > VER_W'(MAX_VER)) |=> (done && !ok && !busy));

    p_no_go_when_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !eng_go);

    p_key_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(key_out));
endmodule

bind key_ladder_seq kl_seq_checker #(
    .KEY_W(KEY_W), .VER_W(VER_W), .MAX_VER(MAX_VER)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .version(version),
    .busy(busy), .done(done), .ok(ok), .key_out(key_out),
    .eng_go(eng_go), .eng_cert_en(eng_cert_en), .eng_done_en(eng_done_en)
);

// File: tb/key_ladder_seq_tb.sv
`timescale 1ns/1ps
module key_ladder_seq_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [7:0]   version = '0;
    logic         busy, done, ok, eng_clr, eng_cert_en, eng_done_en, eng_go;
    logic [255:0] key_out;
    logic [4:0]   eng_cert_idx;
    logic         stub_done, stub_err;
    logic [255:0] stub_st;

    int n_chk = 0, n_err = 0;
    int go_cnt, viol, lat, err_at = 0;
    logic clr_seen;
    logic [4:0] go_log [0:299];

    always #2.5 clk = ~clk;

    key_ladder_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .version(version),
        .busy(busy), .done(done), .ok(ok), .key_out(key_out),
        .eng_clr(eng_clr), .eng_cert_idx(eng_cert_idx), .eng_cert_en(eng_cert_en),
        .eng_done_en(eng_done_en), .eng_go(eng_go), .eng_done(stub_done),
        .eng_err(stub_err), .eng_result(stub_st)
    );

    function automatic logic [255:0] mix(logic [255:0] s, logic [4:0] i);
        return {s[248:0], s[255:249]} ^ {8{27'h5A5A5A5, i}};
    endfunction

    function automatic logic [4:0] exp_idx(int ver, int n);
        int pre [7] = '{0, 3, 4, 5, 7, 15, 20};
        if (n < 7) return 5'(pre[n]);
        if (n < 7 + 254 - ver) return 5'd25;
        return 5'd26;
    endfunction

    // Stub engine: logs steps, checks handshake order, mixes state, injects errors.
    always @(posedge clk) begin
        if (!rst_n) begin
            stub_st <= '0; stub_done <= 0; stub_err <= 0; go_cnt <= 0;
            viol <= 0; lat <= 0; clr_seen <= 0;
        end else begin
            if (start && !busy) begin stub_st <= '0; go_cnt <= 0; end
            if (eng_clr) begin stub_done <= 0; clr_seen <= 1; end
            if (eng_go) begin
                if (!clr_seen || !eng_cert_en || !eng_done_en) viol <= viol + 1;
                clr_seen <= 0;
                if (go_cnt < 300) go_log[go_cnt] <= eng_cert_idx;
                go_cnt  <= go_cnt + 1;
                stub_st <= mix(stub_st, eng_cert_idx);
                stub_err <= (go_cnt + 1 == err_at);
                lat <= 2;
            end else if (lat > 0) begin
                lat <= lat - 1;
                if (lat == 1) stub_done <= 1;
            end
        end
    end

    task automatic chk(bit cond, string req, string what, logic [255:0] act, logic [255:0] exp);
        n_chk++;
        if (!cond) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One run: version ver, error injected on step err_step (0 = none),
    // optional second start while busy with version mid_ver.
    task automatic run_case(int ver, int err_step, bit mid_start, int mid_ver);
        int rep = 254 - ver, total = 8 + (254 - ver), exp_n, t = 0, v0;
        logic [255:0] ek = '0;
        bit seq_ok_pre = 1, seq_ok_rep = 1, seq_ok_suf = 1;
        exp_n = (err_step > 0) ? err_step : total;
        for (int n = 0; n < total; n++) ek = mix(ek, exp_idx(ver, n));
        err_at = err_step;
        v0 = viol;
        @(negedge clk); version = 8'(ver); start = 1;
        @(negedge clk); start = 0;
        chk(busy == 1, "R8", "busy after accepted start", 256'(busy), 1);
        if (mid_start) begin
            repeat (10) @(negedge clk);
            version = 8'(mid_ver); start = 1;
            @(negedge clk); start = 0;
        end
        while (!done && t < 5000) begin @(negedge clk); t++; end
        chk(done == 1, "R8", "done seen", 256'(done), 1);
        chk(busy == 0, "R8", "busy low with done", 256'(busy), 0);
        if (err_step > 0) begin
            chk(ok == 0, "R6", "ok after error", 256'(ok), 0);
            chk(key_out == '0, "R6", "key zero after error", key_out, '0);
        end else begin
            chk(ok == 1, "R7", "ok after success", 256'(ok), 1);
            chk(key_out == ek, "R7", "derived key", key_out, ek);
        end
        @(negedge clk);
        chk(done == 0, "R8", "done one cycle", 256'(done), 0);
        repeat (20) @(negedge clk);
        chk(go_cnt == exp_n, mid_start ? "R9" : (err_step > 0 ? "R6" : "R2"),
            "step count", 256'(go_cnt), 256'(exp_n));
        for (int n = 0; n < exp_n && n < 300; n++) begin
            if (go_log[n] != exp_idx(ver, n)) begin
                if (n < 7) seq_ok_pre = 0;
                else if (n < 7 + rep) seq_ok_rep = 0;
                else seq_ok_suf = 0;
            end
        end
        chk(seq_ok_pre, "R1", "prefix order", 0, 0);
        chk(seq_ok_rep, "R2", "repeated certificate", 0, 0);
        if (err_step == 0)
            chk(seq_ok_suf && go_log[total-1] == 5'd26, "R3", "final certificate",
                256'(go_log[total-1]), 26);
        chk(viol == v0, "R5", "handshake order violations", 256'(viol - v0), 0);
    endtask

    task automatic t_reset();
        chk(busy == 0 && done == 0 && ok == 0 && eng_go == 0, "R10", "reset controls",
            {busy, done, ok, eng_go}, 0);
        chk(key_out == '0, "R10", "reset key", key_out, '0);
    endtask

    task automatic t_bad_version(int ver);
        @(negedge clk); version = 8'(ver); start = 1;
        @(negedge clk); start = 0;
        chk(done == 1 && ok == 0, "R4", "reject pulse", {done, ok}, 2'b10);
        chk(key_out == '0, "R4", "reject key zero", key_out, '0);
        repeat (10) @(negedge clk);
        chk(go_cnt == 0, "R4", "no steps on reject", 256'(go_cnt), 0);
    endtask

    task automatic t_key_hold();
        logic [255:0] k = key_out;
        repeat (30) @(negedge clk);
        chk(key_out == k, "R10", "key held while idle", key_out, k);
    endtask

    initial begin
        #(200000 * 5.0);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        run_case(254, 0, 0, 0);    // no repeats
        t_key_hold();
        run_case(250, 0, 0, 0);    // four repeats
        run_case(0, 0, 0, 0);      // 254 repeats
        t_key_hold();
        t_bad_version(255);
        run_case(250, 3, 0, 0);    // error inside prefix
        run_case(240, 12, 0, 0);   // error in repeated phase
        run_case(252, 0, 1, 0);    // start while busy is ignored
        run_case(253, 9, 0, 0);    // error on the final step
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule